// File: doc/BRIEF.md
# Debounced GPIO Port with Per-Pin Interrupts

An eight-pin general-purpose I/O port seen through a small word-addressed register bus. Each pin is an input or an output by its own direction bit. Reading the data register gives the level actually present on the pins, whatever the direction. Every input passes through a two-flop synchroniser. It can then go through a slow debounce filter driven by a divided-down tick of about 128 Hz.

Each pin can raise an interrupt. The trigger is chosen per pin from two bits: trigger kind (level or edge) and polarity (high/rising or low/falling). Edge events latch into sticky status bits, which are cleared by writing 1 to them. Level status simply tracks the conditioned pin. A mask register selects which status bits reach the single combined interrupt line. Pad drivers, pull-ups and the downstream interrupt controller sit outside the block.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, `pin_oe`, `pin_out`, `irq` and every register read back as zero. A direction bit of 1 drives the matching `pin_oe` bit high (output), and 0 makes the pin an input.
- R2: A write to the data register (byte offset 0x00) updates only the output-latch bits whose direction bit is 1. Latch bits of input pins keep their value, and that value reappears on `pin_out` once the pin is turned into an output.
- R3: A read of the data register returns `pin_in` after a two-flop synchroniser. It does not return the output latch, for any direction setting.
- R4: Registers sit at byte offsets 0x00 data, 0x04 direction, 0x08 polarity, 0x0C trigger kind, 0x10 debounce enable, 0x14 mask, 0x18 status. Bits above bit 7 are dropped on write and read as zero, and unused offsets read as zero. Read data appears on `bus_rdata` one clock after `bus_rd`.
- R5: With trigger kind 0 (level), the status bit is 1 while the conditioned pin equals its polarity bit (polarity 1 = high, 0 = low). It follows the pin back down when the level goes away.
- R6: With trigger kind 1 (edge), the status bit is set by a rising edge when polarity is 1, or by a falling edge when polarity is 0. The opposite edge leaves it unchanged, and it stays set after the pin returns.
- R7: Writing the status register clears exactly the edge-kind bits written as 1. Other edge bits and all level-kind bits are unaffected.
- R8: `irq` is the OR of status AND mask, registered. It rises no later than 4 clocks after the pin change and is 0 whenever the mask was zero on the previous clock. Status is still readable while masked.
- R9: With debounce enabled for a pin, the pin is sampled once every `TICK_DIV` clocks into a 2-bit shift register, and the conditioned level changes only when both stages agree. A pulse shorter than one tick period therefore has no effect, while a level held for several tick periods passes through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register, word aligned |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_rd | input | 1 | Read strobe, data returned next clock |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Registered read data |
| pin_in | input | NPINS | Level seen on the pads |
| pin_out | output | NPINS | Output latch driven towards the pads |
| pin_oe | output | NPINS | Per-pin output enable (direction) |
| irq | output | 1 | Combined masked interrupt |

## Verification
A corrupted output latch or direction register shows on `pin_out`/`pin_oe` one clock after the offending write. A stale synchroniser shows in a data-register read taken three clocks after the pad changes. A status bit in the wrong state appears on a status read two clocks later, and on `irq` one clock after that if it is unmasked. A fault in the debounce path is slower to surface, because it only appears after one or two tick periods. The bench therefore checks both that a short glitch stays invisible over several ticks and that a held level gets through within a bounded wait.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  // word indices (byte offset / 4) of the port registers
  localparam int unsigned WIDX_DATA = 0;
  localparam int unsigned WIDX_DIR  = 1;
  localparam int unsigned WIDX_POL  = 2;
  localparam int unsigned WIDX_KIND = 3;
  localparam int unsigned WIDX_DEB  = 4;
  localparam int unsigned WIDX_MASK = 5;
  localparam int unsigned WIDX_STAT = 6;
endpackage

// File: rtl/gpio_tick_gen.sv
module gpio_tick_gen #(
  parameter int unsigned TICK_DIV = 390625
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      tick  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      tick  <= 1'b0;
    end
  end
endmodule

// File: rtl/gpio_pin_cond.sv
module gpio_pin_cond #(
  parameter int unsigned NPINS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] deb_en,
  output logic [NPINS-1:0] sync_lvl,
  output logic [NPINS-1:0] cond_lvl
);
  logic [NPINS-1:0] meta_q;
  logic [NPINS-1:0] filt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q   <= '0;
      sync_lvl <= '0;
    end else begin
      meta_q   <= pin_in;
      sync_lvl <= meta_q;
    end
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_deb
    logic [1:0] hist_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        hist_q    <= 2'b00;
        filt_q[p] <= 1'b0;
      end else begin
        if (tick) hist_q <= {hist_q[0], sync_lvl[p]};
        if (hist_q[1] == hist_q[0]) filt_q[p] <= hist_q[0];
      end
    end
    assign cond_lvl[p] = deb_en[p] ? filt_q[p] : sync_lvl[p];
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned NPINS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] cond_lvl,
  input  logic [NPINS-1:0] pol,
  input  logic [NPINS-1:0] kind,
  input  logic [NPINS-1:0] clr,
  output logic [NPINS-1:0] stat
);
  logic [NPINS-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= cond_lvl;
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_det
    logic rise, fall, hit;
    assign rise = cond_lvl[p] & ~prev_q[p];
    assign fall = ~cond_lvl[p] & prev_q[p];
    assign hit  = pol[p] ? rise : fall;
    always_ff @(posedge clk) begin
      if (rst)          stat[p] <= 1'b0;
      else if (kind[p]) stat[p] <= (stat[p] & ~clr[p]) | hit;
      else              stat[p] <= (cond_lvl[p] == pol[p]);
    end
  end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS    = 8,
  parameter int unsigned BUS_W    = 32,
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned TICK_DIV = 390625
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);
  localparam int unsigned WW = ADDR_W - 2;

  logic [WW-1:0]    widx;
  logic [NPINS-1:0] wbyte;
  logic [NPINS-1:0] out_q, dir_q, pol_q, kind_q, deb_q, mask_q;
  logic [NPINS-1:0] sync_lvl, cond_lvl, stat_q, clr, rd_mux;
  logic             tick;
  logic             unused_bits;

  assign widx        = bus_addr[ADDR_W-1:2];
  assign wbyte       = bus_wdata[NPINS-1:0];
  assign unused_bits = ^{bus_wdata[BUS_W-1:NPINS], bus_addr[1:0]};

  gpio_tick_gen #(.TICK_DIV(TICK_DIV)) i_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  gpio_pin_cond #(.NPINS(NPINS)) i_cond (
    .clk(clk), .rst(rst), .tick(tick), .pin_in(pin_in), .deb_en(deb_q),
    .sync_lvl(sync_lvl), .cond_lvl(cond_lvl)
  );

  assign clr = (bus_wr && widx == WW'(WIDX_STAT)) ? wbyte : '0;

  gpio_irq_detect #(.NPINS(NPINS)) i_det (
    .clk(clk), .rst(rst), .cond_lvl(cond_lvl), .pol(pol_q), .kind(kind_q),
    .clr(clr), .stat(stat_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= '0;
      dir_q  <= '0;
      pol_q  <= '0;
      kind_q <= '0;
      deb_q  <= '0;
      mask_q <= '0;
    end else if (bus_wr) begin
      case (widx)
        WW'(WIDX_DATA): out_q  <= (out_q & ~dir_q) | (wbyte & dir_q);
        WW'(WIDX_DIR):  dir_q  <= wbyte;
        WW'(WIDX_POL):  pol_q  <= wbyte;
        WW'(WIDX_KIND): kind_q <= wbyte;
        WW'(WIDX_DEB):  deb_q  <= wbyte;
        WW'(WIDX_MASK): mask_q <= wbyte;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (widx)
      WW'(WIDX_DATA): rd_mux = sync_lvl;
      WW'(WIDX_DIR):  rd_mux = dir_q;
      WW'(WIDX_POL):  rd_mux = pol_q;
      WW'(WIDX_KIND): rd_mux = kind_q;
      WW'(WIDX_DEB):  rd_mux = deb_q;
      WW'(WIDX_MASK): rd_mux = mask_q;
      WW'(WIDX_STAT): rd_mux = stat_q;
      default:        rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      bus_rdata <= bus_rd ? {{(BUS_W-NPINS){1'b0}}, rd_mux} : '0;
      irq       <= |(stat_q & mask_q);
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS  = 8,
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic [NPINS-1:0]  pin_out,
  input logic [NPINS-1:0]  pin_oe,
  input logic              irq,
  input logic [NPINS-1:0]  mask_q,
  input logic [NPINS-1:0]  kind_q,
  input logic [NPINS-1:0]  stat_q,
  input logic              tick
);
  localparam int unsigned WW = ADDR_W - 2;
  logic [WW-1:0] widx;
  logic          unused_lo;
  assign widx      = bus_addr[ADDR_W-1:2];
  assign unused_lo = ^{bus_addr[1:0], bus_wdata[BUS_W-1:NPINS]};

  // R1
  dir_to_oe_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && widx == WW'(WIDX_DIR)) |=> (pin_oe == $past(bus_wdata[NPINS-1:0])));

  // R2
  input_latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && widx == WW'(WIDX_DATA)) |=> ((pin_out & ~pin_oe) == ($past(pin_out) & ~pin_oe)));

  // R4
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[BUS_W-1:NPINS] == '0);

  // R6
  edge_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (!(bus_wr && (widx == WW'(WIDX_STAT) || widx == WW'(WIDX_KIND))))
      |=> ((($past(stat_q) & $past(kind_q)) & ~stat_q) == '0));

  // R8
  masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(mask_q) == '0) |-> !irq);

  // R9
  tick_single_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPINS(NPINS), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq),
  .mask_q(mask_q), .kind_q(kind_q), .stat_q(stat_q), .tick(tick)
);

// File: tb/test_gpio_irq_port.sv
`timescale 1ns/1ps
module test_gpio_irq_port;
  localparam int unsigned NPINS = 8;
  localparam int unsigned TDIV  = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pin_in, pin_out, pin_oe, ext = '0;
  logic        irq;
  int          n_chk = 0;
  int          n_bad = 0;
  logic [31:0] rv;

  always #2 clk = ~clk;

  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

  gpio_irq_port #(.NPINS(NPINS), .TICK_DIV(TDIV)) i_gpio_irq_port (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // {dir, data written, external level, expected pin_out, expected data read}
  localparam logic [39:0] VEC [6] = '{
    {8'hFF, 8'hA5, 8'h00, 8'hA5, 8'hA5},
    {8'h0F, 8'h3C, 8'hF0, 8'hAC, 8'hFC},
    {8'h00, 8'hFF, 8'h5A, 8'hAC, 8'h5A},
    {8'hF0, 8'h12, 8'h0F, 8'h1C, 8'h1F},
    {8'hFF, 8'h00, 8'hFF, 8'h00, 8'h00},
    {8'h00, 8'h00, 8'hC3, 8'h00, 8'hC3}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    check("R1 reset pin_oe", {24'h0, pin_oe}, 32'h0);
    check("R1 reset pin_out", {24'h0, pin_out}, 32'h0);
    check("R1 reset irq", {31'h0, irq}, 32'h0);
    rd(5'h04, rv); check("R1 reset dir read", rv, 32'h0);

    // R4 upper bits dropped, unused offset reads zero
    wr(5'h14, 32'hABCDEF5A);
    rd(5'h14, rv); check("R4 mask upper bits", rv, 32'h0000005A);
    wr(5'h14, 32'h0);
    rd(5'h1C, rv); check("R4 unused offset", rv, 32'h0);

    // vector table: R1 R2 R3
    for (int v = 0; v < 6; v++) begin
      wr(5'h04, {24'h0, VEC[v][39:32]});
      wr(5'h00, {24'hFFFFFF, VEC[v][31:24]});
      ext = VEC[v][23:16];
      idle(3);
      check($sformatf("R1 vec%0d pin_oe", v), {24'h0, pin_oe}, {24'h0, VEC[v][39:32]});
      check($sformatf("R2 vec%0d pin_out", v), {24'h0, pin_out}, {24'h0, VEC[v][15:8]});
      rd(5'h00, rv);
      check($sformatf("R3 vec%0d data read", v), rv, {24'h0, VEC[v][7:0]});
    end

    // all inputs, level low by default: status full but masked
    wr(5'h04, 32'h0); ext = 8'h00; idle(4);
    rd(5'h18, rv); check("R8 status while masked", rv, 32'h000000FF);
    check("R8 irq masked", {31'h0, irq}, 32'h0);

    // R5 level high on pin0
    wr(5'h08, 32'hFF); idle(3);
    rd(5'h18, rv); check("R5 high level idle status", rv, 32'h0);
    wr(5'h14, 32'h01);
    ext = 8'h01; idle(5);
    check("R5 R8 level high irq", {31'h0, irq}, 32'h1);
    ext = 8'h00; idle(5);
    check("R5 level released irq", {31'h0, irq}, 32'h0);

    // R5 level low on pin1
    wr(5'h08, 32'hFD); wr(5'h14, 32'h02); idle(5);
    check("R5 level low irq", {31'h0, irq}, 32'h1);
    ext = 8'h02; idle(5);
    check("R5 level low released", {31'h0, irq}, 32'h0);
    wr(5'h14, 32'h0); wr(5'h08, 32'hFF);
    ext = 8'h00; idle(4);

    // R6 R7 edges: pin2 rising, pin3 falling
    wr(5'h0C, 32'h0C); wr(5'h08, 32'hF7); idle(3);
    wr(5'h18, 32'h0C); idle(2);
    rd(5'h18, rv); check("R7 edge status cleared", rv, 32'h0);
    wr(5'h14, 32'h0C);
    ext = 8'h04; idle(5);
    check("R6 rising irq", {31'h0, irq}, 32'h1);
    rd(5'h18, rv); check("R6 rising status", rv, 32'h04);
    ext = 8'h00; idle(5);
    rd(5'h18, rv); check("R6 sticky after return", rv, 32'h04);
    wr(5'h18, 32'h04); idle(3);
    check("R7 clear drops irq", {31'h0, irq}, 32'h0);
    ext = 8'h08; idle(5);
    rd(5'h18, rv); check("R6 wrong edge ignored", rv, 32'h0);
    ext = 8'h00; idle(5);
    rd(5'h18, rv); check("R6 falling status", rv, 32'h08);
    check("R8 falling irq", {31'h0, irq}, 32'h1);
    ext = 8'h04; idle(5);
    rd(5'h18, rv); check("R6 two edges", rv, 32'h0C);
    wr(5'h18, 32'h08); idle(2);
    rd(5'h18, rv); check("R7 clears only written bit", rv, 32'h04);
    wr(5'h18, 32'h04);
    ext = 8'h01; idle(5);
    wr(5'h18, 32'h01); idle(2);
    rd(5'h18, rv); check("R7 level bit not cleared", rv, 32'h01);
    ext = 8'h00; idle(4);

    // R9 debounce on pin4 rising edge
    wr(5'h14, 32'h0); wr(5'h0C, 32'h1C); wr(5'h10, 32'h10);
    idle(3); wr(5'h18, 32'hFF); idle(2);
    rd(5'h18, rv); check("R9 debounce start status", rv, 32'h0);
    wr(5'h14, 32'h10);
    ext = 8'h10; idle(3); ext = 8'h00;
    idle(30);
    rd(5'h18, rv); check("R9 glitch filtered", rv, 32'h0);
    check("R9 glitch irq", {31'h0, irq}, 32'h0);
    ext = 8'h10; idle(4);
    rd(5'h18, rv); check("R9 not yet through", rv, 32'h0);
    idle(40);
    rd(5'h18, rv); check("R9 held level through", rv, 32'h10);
    check("R9 debounced irq", {31'h0, irq}, 32'h1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule